// File: doc/BRIEF.md
# Resumable NMI CSR Unit

This block keeps the machine-level state a small 32-bit core needs to take a resumable non-maskable interrupt and return from it. The core supports only Machine and User privilege. The unit holds four control registers: a scratch word, the saved program counter, the cause word and a status word. Software reads and writes them through a single-cycle CSR port.

When the core takes an NMI it pulses `nmi_take` together with the interrupted PC, the cause code, an interrupt flag and the privilege it was running in. In the same clock edge the unit saves that state and clears the NMI interrupt enable. When the core executes the return instruction it pulses `mnret`. The unit then sets the enable again, and the core reads the resume PC and resume privilege from the registered outputs.

Writes to the previous-privilege field are legalised: any encoding other than User becomes Machine. Hardware events take priority over a software write to the same register in the same cycle.

Top module: `rnmi_csr_unit`

## Requirements
- R1: After a synchronous reset, the scratch, saved-PC and cause registers read 0. The status register reads 0x0000_1800 (previous privilege Machine, enable 0). `resume_pc` is 0, `resume_priv` is 2'b11 and `nmie_out` is 0.
- R2: `csr_rdata` is combinational from the current register state. Address 0x740 returns scratch, 0x741 the saved PC, 0x742 the cause and 0x744 the status. Every other address returns 0.
- R3: Scratch is a plain 32-bit read/write register. A write is visible on a read in the cycle after the write edge.
- R4: Bit 0 of the saved PC always reads 0, both after a CSR write and after an NMI capture. `resume_pc` always equals the saved PC.
- R5: On `nmi_take` the saved PC becomes `nmi_pc` with bit 0 cleared, and the cause becomes {`nmi_is_irq`, `nmi_cause`}. The previous privilege becomes the legalised `cur_priv`, and the enable clears to 0.
- R6: Cause bit 31 cannot be written by software. A CSR write changes only bits 30:0.
- R7: Status stores only bits 12:11 (previous privilege) and bit 3 (enable), and all other bits read 0. A written privilege of 2'b01 or 2'b10 is stored as 2'b11. `resume_priv` only ever shows 2'b00 or 2'b11.
- R8: On `mnret` without `nmi_take`, the enable becomes 1. `resume_priv` shows the stored previous privilege, and the saved PC is unchanged.
- R9: When `nmi_take` coincides with a CSR write to the saved PC, cause or status, the captured values win. When `mnret` coincides with a status write, the whole status write is dropped.
- R10: Software can set the enable back to 1 by writing status bit 3 while inside the handler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | CSR write enable |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for `csr_addr` |
| nmi_take | input | 1 | NMI entry pulse |
| nmi_pc | input | 32 | PC of the interrupted instruction |
| nmi_cause | input | 31 | NMI cause code |
| nmi_is_irq | input | 1 | Entry was caused by an interrupt |
| cur_priv | input | 2 | Privilege at entry |
| mnret | input | 1 | Return-from-NMI pulse |
| resume_pc | output | 32 | PC to resume at after return |
| resume_priv | output | 2 | Privilege to resume in |
| nmie_out | output | 1 | NMI interrupt enable |

## Verification
The bench drives the illegal privilege encodings through both the CSR port and the entry capture. A unit that stored them raw would show 2'b01 or 2'b10 on `resume_priv`. The bench also writes odd PCs and an all-ones cause word. A faulty unit would leave bit 0 of the resume PC set, or let software forge the interrupt flag. It collides entry and return with writes to the same registers: a wrong priority would leave the handler with interrupts enabled, or with a software PC in place of the captured one. Read-backs of unmapped neighbours 0x743 and 0x745 catch a loose address decode.

// File: rtl/rnmi_pkg.sv
package rnmi_pkg;
  localparam logic [11:0] ADR_SCRATCH = 12'h740;
  localparam logic [11:0] ADR_EPC     = 12'h741;
  localparam logic [11:0] ADR_CAUSE   = 12'h742;
  localparam logic [11:0] ADR_STATUS  = 12'h744;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam int PP_LSB = 11;
  localparam int IE_BIT = 3;

  function automatic logic [1:0] legal_priv(input logic [1:0] p);
    return (p == PRIV_U) ? PRIV_U : PRIV_M;
  endfunction
endpackage

// File: rtl/rnmi_word_reg.sv
module rnmi_word_reg #(
  parameter int          W     = 32,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sw_we,
  input  logic [W-1:0] sw_data,
  input  logic         hw_we,
  input  logic [W-1:0] hw_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (hw_we) begin
      q <= hw_data;
    end else if (sw_we) begin
      q <= (q & ~WMASK) | (sw_data & WMASK);
    end
  end
endmodule

// File: rtl/rnmi_status_reg.sv
module rnmi_status_reg
  import rnmi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_we,
  input  logic [1:0] sw_pp,
  input  logic       sw_ie,
  input  logic       take,
  input  logic [1:0] take_priv,
  input  logic       ret,
  output logic [1:0] pp,
  output logic       ie
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pp <= PRIV_M;
      ie <= 1'b0;
    end else if (take) begin
      pp <= legal_priv(take_priv);
      ie <= 1'b0;
    end else if (ret) begin
      ie <= 1'b1;
    end else if (sw_we) begin
      pp <= legal_priv(sw_pp);
      ie <= sw_ie;
    end
  end
endmodule

// File: rtl/rnmi_rdmux.sv
module rnmi_rdmux
  import rnmi_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      scratch,
  input  logic [W-1:0]      epc,
  input  logic [W-1:0]      cause,
  input  logic [W-1:0]      status,
  output logic [W-1:0]      rdata
);
  always_comb begin
    case (addr)
      ADDR_W'(ADR_SCRATCH): rdata = scratch;
      ADDR_W'(ADR_EPC):     rdata = epc;
      ADDR_W'(ADR_CAUSE):   rdata = cause;
      ADDR_W'(ADR_STATUS):  rdata = status;
      default:              rdata = '0;
    endcase
  end
endmodule

// File: rtl/rnmi_csr_unit.sv
module rnmi_csr_unit
  import rnmi_pkg::*;
#(
  parameter int DATA_W          = 32,
  parameter int ADDR_W          = 12,
  parameter bit CAUSE_SUPPORTED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_we,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic              nmi_take,
  input  logic [DATA_W-1:0] nmi_pc,
  input  logic [DATA_W-2:0] nmi_cause,
  input  logic              nmi_is_irq,
  input  logic [1:0]        cur_priv,
  input  logic              mnret,
  output logic [DATA_W-1:0] resume_pc,
  output logic [1:0]        resume_priv,
  output logic              nmie_out
);
  localparam logic [DATA_W-1:0] SCR_MASK = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] EPC_MASK = {{(DATA_W-1){1'b1}}, 1'b0};
  localparam logic [DATA_W-1:0] CAU_MASK =
    CAUSE_SUPPORTED ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b0}};

  logic we_scr, we_epc, we_cau, we_sts;
  assign we_scr = csr_we && (csr_addr == ADDR_W'(ADR_SCRATCH));
  assign we_epc = csr_we && (csr_addr == ADDR_W'(ADR_EPC));
  assign we_cau = csr_we && (csr_addr == ADDR_W'(ADR_CAUSE));
  assign we_sts = csr_we && (csr_addr == ADDR_W'(ADR_STATUS));

  logic [DATA_W-1:0] scr_q, epc_q, cau_q, sts_word, cau_hw;
  logic [1:0]        pp_q;
  logic              ie_q;

  generate
    if (CAUSE_SUPPORTED) begin : g_cause_full
      assign cau_hw = {nmi_is_irq, nmi_cause};
    end else begin : g_cause_flag
      logic unused_cause;
      assign unused_cause = ^nmi_cause;
      assign cau_hw = {nmi_is_irq, {(DATA_W-1){1'b0}}};
    end
  endgenerate

  rnmi_word_reg #(.W(DATA_W), .WMASK(SCR_MASK)) u_scratch (
    .clk(clk), .rst(rst), .sw_we(we_scr), .sw_data(csr_wdata),
    .hw_we(1'b0), .hw_data({DATA_W{1'b0}}), .q(scr_q));

  rnmi_word_reg #(.W(DATA_W), .WMASK(EPC_MASK)) u_epc (
    .clk(clk), .rst(rst), .sw_we(we_epc), .sw_data(csr_wdata),
    .hw_we(nmi_take), .hw_data(nmi_pc & EPC_MASK), .q(epc_q));

  rnmi_word_reg #(.W(DATA_W), .WMASK(CAU_MASK)) u_cause (
    .clk(clk), .rst(rst), .sw_we(we_cau), .sw_data(csr_wdata),
    .hw_we(nmi_take), .hw_data(cau_hw), .q(cau_q));

  rnmi_status_reg u_status (
    .clk(clk), .rst(rst), .sw_we(we_sts),
    .sw_pp(csr_wdata[PP_LSB +: 2]), .sw_ie(csr_wdata[IE_BIT]),
    .take(nmi_take), .take_priv(cur_priv), .ret(mnret),
    .pp(pp_q), .ie(ie_q));

  always_comb begin
    sts_word               = '0;
    sts_word[PP_LSB +: 2]  = pp_q;
    sts_word[IE_BIT]       = ie_q;
  end

  rnmi_rdmux #(.W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .addr(csr_addr), .scratch(scr_q), .epc(epc_q), .cause(cau_q),
    .status(sts_word), .rdata(csr_rdata));

  assign resume_pc   = epc_q;
  assign resume_priv = pp_q;
  assign nmie_out    = ie_q;
endmodule

// File: rtl/rnmi_csr_checker.sv
module rnmi_csr_checker
  import rnmi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] csr_addr,
  input logic              csr_we,
  input logic              nmi_take,
  input logic [DATA_W-1:0] nmi_pc,
  input logic              mnret,
  input logic [DATA_W-1:0] resume_pc,
  input logic [1:0]        resume_priv,
  input logic              nmie_out
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (resume_pc == '0 && resume_priv == PRIV_M && !nmie_out)); // R1
  AST_EPC_EVEN: assert property (@(posedge clk) disable iff (rst)
    resume_pc[0] == 1'b0); // R4
  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (rst)
    nmi_take |=> !nmie_out); // R5
  AST_ENTRY_PC: assert property (@(posedge clk) disable iff (rst)
    nmi_take |=> resume_pc[DATA_W-1:1] == $past(nmi_pc[DATA_W-1:1])); // R5
  AST_PRIV_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (resume_priv == PRIV_U || resume_priv == PRIV_M)); // R7
  AST_RET_UNMASKS: assert property (@(posedge clk) disable iff (rst)
    (mnret && !nmi_take) |=> nmie_out); // R8
  AST_ENTRY_BEATS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (nmi_take && csr_we && csr_addr == ADDR_W'(ADR_STATUS)) |=> !nmie_out); // R9
endmodule

bind rnmi_csr_unit rnmi_csr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_we(csr_we),
  .nmi_take(nmi_take), .nmi_pc(nmi_pc), .mnret(mnret),
  .resume_pc(resume_pc), .resume_priv(resume_priv), .nmie_out(nmie_out));

// File: tb/sim_rnmi_csr_unit.sv
`timescale 1ns/1ps
module sim_rnmi_csr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] csr_addr = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        nmi_take = 1'b0;
  logic [31:0] nmi_pc = '0;
  logic [30:0] nmi_cause = '0;
  logic        nmi_is_irq = 1'b0;
  logic [1:0]  cur_priv = 2'b11;
  logic        mnret = 1'b0;
  logic [31:0] resume_pc;
  logic [1:0]  resume_priv;
  logic        nmie_out;

  int n_cmp = 0;
  int n_bad = 0;

  // reference state
  logic [31:0] m_scr = '0, m_epc = '0, m_cau = '0;
  logic [1:0]  m_pp = 2'b11;
  logic        m_ie = 1'b0;

  always #4 clk = ~clk;

  rnmi_csr_unit u0 (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .nmi_take(nmi_take),
    .nmi_pc(nmi_pc), .nmi_cause(nmi_cause), .nmi_is_irq(nmi_is_irq),
    .cur_priv(cur_priv), .mnret(mnret), .resume_pc(resume_pc),
    .resume_priv(resume_priv), .nmie_out(nmie_out));

  function automatic logic [1:0] fix_priv(input logic [1:0] p);
    return (p == 2'b00) ? 2'b00 : 2'b11;
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      12'h740: return m_scr;
      12'h741: return m_epc;
      12'h742: return m_cau;
      12'h744: return (32'(m_pp) << 11) | (32'(m_ie) << 3);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "rdata", csr_rdata, model_read(csr_addr));
    chk(tag, "resume_pc", resume_pc, m_epc);
    chk(tag, "resume_priv", 32'(resume_priv), 32'(m_pp));
    chk(tag, "nmie", 32'(nmie_out), 32'(m_ie));
  endtask

  // one clock: drive at negedge, check pre-edge read, update model at edge, check after
  task automatic cyc(input string tag, input logic [11:0] a, input logic we,
                     input logic [31:0] wd, input logic tk, input logic [31:0] pc,
                     input logic [30:0] code, input logic irq, input logic [1:0] pv,
                     input logic rt);
    logic [31:0] n_scr, n_epc, n_cau;
    logic [1:0]  n_pp;
    logic        n_ie;
    csr_addr = a; csr_we = we; csr_wdata = wd; nmi_take = tk; nmi_pc = pc;
    nmi_cause = code; nmi_is_irq = irq; cur_priv = pv; mnret = rt;
    #1;
    chk(tag, "rdata_pre", csr_rdata, model_read(a));
    n_scr = m_scr; n_epc = m_epc; n_cau = m_cau; n_pp = m_pp; n_ie = m_ie;
    if (we) begin
      if (a == 12'h740) n_scr = wd;
      if (a == 12'h741) n_epc = {wd[31:1], 1'b0};
      if (a == 12'h742) n_cau = {m_cau[31], wd[30:0]};
      if (a == 12'h744 && !tk && !rt) begin
        n_pp = fix_priv(wd[12:11]);
        n_ie = wd[3];
      end
    end
    if (tk) begin
      n_epc = {pc[31:1], 1'b0};
      n_cau = {irq, code};
      n_pp  = fix_priv(pv);
      n_ie  = 1'b0;
    end else if (rt) begin
      n_ie = 1'b1;
    end
    @(posedge clk);
    m_scr = n_scr; m_epc = n_epc; m_cau = n_cau; m_pp = n_pp; m_ie = n_ie;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    cyc(tag, a, 1'b0, 32'h0, 1'b0, 32'h0, 31'h0, 1'b0, 2'b11, 1'b0);
  endtask

  task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d);
    cyc(tag, a, 1'b1, d, 1'b0, 32'h0, 31'h0, 1'b0, 2'b11, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_all("R1");
    // R2: every mapped address plus unmapped neighbours
    rd("R2", 12'h740); rd("R2", 12'h741); rd("R2", 12'h742);
    rd("R2", 12'h744); rd("R2", 12'h743); rd("R2", 12'h745);
    // R3 scratch
    wr("R3", 12'h740, 32'hDEADBEEF); rd("R3", 12'h740);
    // R4 odd PC write
    wr("R4", 12'h741, 32'h12345677); rd("R4", 12'h741);
    // R6 cause bit 31 read-only
    wr("R6", 12'h742, 32'hFFFFFFFF); rd("R6", 12'h742);
    // R7 status masks and legalisation
    wr("R7", 12'h744, 32'hFFFFFFFF); rd("R7", 12'h744);
    wr("R7", 12'h744, 32'h00000800); rd("R7", 12'h744);
    wr("R7", 12'h744, 32'h00001000); rd("R7", 12'h744);
    wr("R7", 12'h744, 32'h00000000); rd("R7", 12'h744);
    rd("R2", 12'h743);
    // R5 entry from user mode, odd PC
    cyc("R5", 12'h741, 1'b0, 0, 1'b1, 32'h80000101, 31'd5, 1'b1, 2'b00, 1'b0);
    rd("R5", 12'h742); rd("R5", 12'h744);
    // R10 handler re-enables
    wr("R10", 12'h744, 32'h00000008); rd("R10", 12'h744);
    // R8 return
    cyc("R8", 12'h744, 1'b0, 0, 1'b0, 0, 0, 1'b0, 2'b11, 1'b1);
    rd("R8", 12'h741);
    // R5/R7 entry with illegal privilege
    cyc("R7", 12'h744, 1'b0, 0, 1'b1, 32'h00000044, 31'h7FFFFFFF, 1'b0, 2'b10, 1'b0);
    cyc("R7", 12'h744, 1'b0, 0, 1'b1, 32'h00000048, 31'd3, 1'b1, 2'b01, 1'b0);
    // R9 collisions
    cyc("R9", 12'h741, 1'b1, 32'h11111111, 1'b1, 32'h2222_2223, 31'd9, 1'b0, 2'b00, 1'b0);
    cyc("R9", 12'h742, 1'b1, 32'h0000_0ABC, 1'b1, 32'h3333_3330, 31'd7, 1'b1, 2'b11, 1'b0);
    cyc("R9", 12'h744, 1'b1, 32'h0000_0008, 1'b1, 32'h4444_4440, 31'd1, 1'b0, 2'b00, 1'b0);
    cyc("R9", 12'h744, 1'b1, 32'h0000_0000, 1'b0, 0, 0, 1'b0, 2'b11, 1'b1);
    rd("R9", 12'h744);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      case ($urandom_range(0, 6))
        0: a = 12'h740; 1: a = 12'h741; 2: a = 12'h742; 3: a = 12'h744;
        4: a = 12'h743; 5: a = 12'h745; default: a = 12'h000;
      endcase
      cyc("R2", a, 1'($urandom_range(0, 1)), $urandom(),
          ($urandom_range(0, 7) == 0), $urandom(), 31'($urandom()),
          1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
          ($urandom_range(0, 7) == 0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule